// File: doc/BRIEF.md
# Microword-Driven 16-bit Register Datapath

This block is the execution half of a microprogrammed 16-bit processor. Each clock it takes one 32-bit control word and carries it out in a single cycle. The datapath holds nine 16-bit registers: memory data (MDR), accumulator (A), two index registers (X, Y), memory address (MAR), stack pointer (SP), data pointer (DP), program counter (PC) and the machine status word (MSW).

Two operand buses feed a 16-function ALU. The ALU has an arithmetic mode and a logic mode, an optional carry-in and an optional one-bit right shift. Its result is the write value for whichever destination the control word names. Memory is eight bits wide. A bus interface either replaces one byte of the write value with the byte read from memory, or sends one byte of the ALU result out to memory. A 16-bit value therefore moves in two microwords.

Condition flags can be latched from the whole 16-bit result, from its high byte or from its low byte. PC, MAR and SP can step by one without using the ALU. The sequencer that supplies the control words, and the memory itself, sit outside the block.

Top module: `ucode_datapath`

## Requirements
- R1: The control word is split into these fields:
  - bits [1:0]: left-bus select
  - bits [3:2]: right-bus select
  - bits [5:4]: address select
  - bits [7:6]: bus-interface mode
  - bit 8: bus-interface enable
  - bits [12:9]: load destination
  - bit 13: instruction-register load strobe
  - bits [17:14]: ALU function
  - bit 18: logic mode
  - bit 19: carry-in
  - bit 20: right shift
  - bits [22:21]: flags-latch mode
  - bit 23: PC increment
  - bit 24: MAR increment
  - bit 25: SP increment
  - bit 26: SP decrement
  - bit 27: data segment
  - bit 28: privileged
  - bits [31:29]: ignored
- R2: After reset every register reads zero. This is observable as `alu_out` for each left-bus source and for MSW, and as `mem_addr` for each address source.
- R3: Left-bus codes: 0 selects MDR, 1 selects A, 2 selects X, 3 selects Y. Right-bus codes: 0 selects MDR, 1 selects MSW, 2 selects the current memory address, 3 gives zero.
- R4: `mem_addr` shows MAR, SP, DP or PC for address codes 0, 1, 2 and 3.
- R5: The load code picks exactly one destination: 0 MDR low, 1 MDR high, 2 MDR, 3 A low, 4 A high, 5 A, 6 X, 7 Y, 8 memory, 9 MAR low, 10 MAR high, 11 MAR, 12 SP, 13 DP, 14 PC, 15 MSW. A byte destination changes only its own byte.
- R6: With the interface enabled, the four modes behave as follows. Mode 0 replaces the low byte of the write value with `mem_rdata`, and mode 1 replaces the high byte; both raise `mem_re`. Mode 2 sends the ALU low byte to `mem_wdata`, and mode 3 sends the high byte. `mem_we` rises only in modes 2 and 3 with the enable set and load code 8; otherwise memory is not written.
- R7: In logic mode, functions 0 to 15 produce the following (A is the left bus, B is the right bus):
  - 0: not A
  - 1: not (A or B)
  - 2: not A and B
  - 3: zero
  - 4: not (A and B)
  - 5: not B
  - 6: A xor B
  - 7: A and not B
  - 8: not A or B
  - 9: not (A xor B)
  - 10: B
  - 11: A and B
  - 12: all ones
  - 13: A or not B
  - 14: A or B
  - 15: A
- R7 (continued): In arithmetic mode, functions 0 to 15 produce the following, plus the carry-in bit:
  - 0: A
  - 1: A or B
  - 2: A or not B
  - 3: minus one
  - 4: A plus (A and not B)
  - 5: (A or B) plus (A and not B)
  - 6: A minus B minus one
  - 7: (A and not B) minus one
  - 8: A plus (A and B)
  - 9: A plus B
  - 10: (A or not B) plus (A and B)
  - 11: (A and B) minus one
  - 12: A plus A
  - 13: (A or B) plus A
  - 14: (A or not B) plus A
  - 15: A minus one
- R7 (continued): The right-shift bit shifts the result right by one, inserts zero at the top and moves the bit shifted out into C.
- R8: MSW bits [3:0] hold C, Z, N and V. Flags-latch mode 0 takes the 16-bit result. Mode 1 takes Z and N from the high byte and C and V from the word. Mode 2 takes all four from the low byte. Mode 3 leaves the flags unchanged. Logic results give C=0 and V=0. A load into MSW overrides the flags latch.
- R9: The PC, MAR and SP increment bits and the SP decrement bit each step their register by one. A load of the same register wins over a step. Asserting SP increment and SP decrement together leaves SP unchanged.
- R10: `seg_data`, `priv` and `ir_load` follow their control-word bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uword | input | 32 | Control word for this cycle |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| mem_addr | output | 16 | Selected memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read in use |
| seg_data | output | 1 | Access targets the data segment (0 = code) |
| priv | output | 1 | Current word is privileged |
| ir_load | output | 1 | Instruction-register load strobe |
| alu_out | output | 16 | ALU result after the optional shift |

## Verification
The assertions check the following on every cycle:
- The write strobe appears only for a memory-destination store, and never together with a read.
- PC and SP step by exactly one when asked.
- Opposite SP steps cancel.
- MSW holds still when neither the flags latch nor a load touches it.

The bench's scenarios are needed for everything that depends on data values:
- the 32 ALU functions and their carries and overflows
- the three flag widths
- byte merging from memory into half-registers
- which byte reaches memory
- loads winning over steps

A cycle-by-cycle model in the bench follows random control words for these.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int W    = 16;
  localparam int BW   = 8;
  localparam int UW   = 32;
  localparam int NLD  = 16;
  localparam int NFLG = 4;

  typedef enum logic [3:0] {
    LD_MDRL, LD_MDRH, LD_MDR, LD_AL, LD_AH, LD_A, LD_X, LD_Y,
    LD_MEM, LD_MARL, LD_MARH, LD_MAR, LD_SP, LD_DP, LD_PC, LD_MSW
  } ld_e;

  typedef enum logic [1:0] {BI_RDLO, BI_RDHI, BI_WRLO, BI_WRHI} bi_e;
  typedef enum logic [1:0] {FL_WORD, FL_HI, FL_LO, FL_NONE} fl_e;

  typedef struct packed {
    logic [1:0] lsel;
    logic [1:0] rsel;
    logic [1:0] asel;
    bi_e        bmode;
    logic       ben;
    ld_e        ld;
    logic       ir;
    logic [3:0] fn;
    logic       lmode;
    logic       cin;
    logic       shr;
    fl_e        fl;
    logic       inc_pc;
    logic       inc_mar;
    logic       inc_sp;
    logic       dec_sp;
    logic       seg;
    logic       priv;
  } ctl_t;

  // Arithmetic operand pair {x, y} for each function code; sum is x+y+cin.
  function automatic logic [2*W-1:0] arith_ops(input logic [3:0] fn,
                                               input logic [W-1:0] a,
                                               input logic [W-1:0] b);
    logic [W-1:0] ones;
    ones = '1;
    case (fn)
      4'd0:    arith_ops = {a, {W{1'b0}}};
      4'd1:    arith_ops = {a | b, {W{1'b0}}};
      4'd2:    arith_ops = {a | ~b, {W{1'b0}}};
      4'd3:    arith_ops = {{W{1'b0}}, ones};
      4'd4:    arith_ops = {a, a & ~b};
      4'd5:    arith_ops = {a | b, a & ~b};
      4'd6:    arith_ops = {a, ~b};
      4'd7:    arith_ops = {a & ~b, ones};
      4'd8:    arith_ops = {a, a & b};
      4'd9:    arith_ops = {a, b};
      4'd10:   arith_ops = {a | ~b, a & b};
      4'd11:   arith_ops = {a & b, ones};
      4'd12:   arith_ops = {a, a};
      4'd13:   arith_ops = {a | b, a};
      4'd14:   arith_ops = {a | ~b, a};
      default: arith_ops = {a, ones};
    endcase
  endfunction

  function automatic logic [W-1:0] logic_fn(input logic [3:0] fn,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    case (fn)
      4'd0:    logic_fn = ~a;
      4'd1:    logic_fn = ~(a | b);
      4'd2:    logic_fn = ~a & b;
      4'd3:    logic_fn = '0;
      4'd4:    logic_fn = ~(a & b);
      4'd5:    logic_fn = ~b;
      4'd6:    logic_fn = a ^ b;
      4'd7:    logic_fn = a & ~b;
      4'd8:    logic_fn = ~a | b;
      4'd9:    logic_fn = ~(a ^ b);
      4'd10:   logic_fn = b;
      4'd11:   logic_fn = a & b;
      4'd12:   logic_fn = '1;
      4'd13:   logic_fn = a | ~b;
      4'd14:   logic_fn = a | b;
      default: logic_fn = a;
    endcase
  endfunction

  // Replace the low and/or high byte of old with the matching byte of val.
  function automatic logic [W-1:0] merge_bytes(input logic [W-1:0] old,
                                               input logic wlo, input logic whi,
                                               input logic [W-1:0] val);
    merge_bytes = old;
    if (wlo) merge_bytes[BW-1:0] = val[BW-1:0];
    if (whi) merge_bytes[W-1:BW] = val[W-1:BW];
  endfunction
endpackage

// File: rtl/dp_decode.sv
module dp_decode import dp_pkg::*; (
  input  logic [UW-1:0]  uword,
  output ctl_t           ctl,
  output logic [NLD-1:0] ld_oh
);
  logic unused_spare;
  assign unused_spare = ^uword[UW-1:29];

  always_comb begin
    ctl.lsel    = uword[1:0];
    ctl.rsel    = uword[3:2];
    ctl.asel    = uword[5:4];
    ctl.bmode   = bi_e'(uword[7:6]);
    ctl.ben     = uword[8];
    ctl.ld      = ld_e'(uword[12:9]);
    ctl.ir      = uword[13];
    ctl.fn      = uword[17:14];
    ctl.lmode   = uword[18];
    ctl.cin     = uword[19];
    ctl.shr     = uword[20];
    ctl.fl      = fl_e'(uword[22:21]);
    ctl.inc_pc  = uword[23];
    ctl.inc_mar = uword[24];
    ctl.inc_sp  = uword[25];
    ctl.dec_sp  = uword[26];
    ctl.seg     = uword[27];
    ctl.priv    = uword[28];
  end

  for (genvar i = 0; i < NLD; i++) begin : g_ld
    assign ld_oh[i] = (uword[12:9] == 4'(i));
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu import dp_pkg::*; (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  input  logic         lmode,
  input  logic         cin,
  input  logic         shr,
  output logic [W-1:0] f,
  output logic         c_word,
  output logic         c_byte,
  output logic         v_word,
  output logic         v_byte
);
  logic [W-1:0]  x, y, pre;
  logic [W:0]    sum_w;
  logic [BW:0]   sum_b;
  logic          cw, cb, vw, vb;

  always_comb begin
    {x, y} = arith_ops(fn, a, b);
    sum_w  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum_b  = {1'b0, x[BW-1:0]} + {1'b0, y[BW-1:0]} + {{BW{1'b0}}, cin};
    if (lmode) begin
      pre = logic_fn(fn, a, b);
      cw = 1'b0; cb = 1'b0; vw = 1'b0; vb = 1'b0;
    end else begin
      pre = sum_w[W-1:0];
      cw  = sum_w[W];
      cb  = sum_b[BW];
      vw  = (x[W-1] == y[W-1]) && (sum_w[W-1] != x[W-1]);
      vb  = (x[BW-1] == y[BW-1]) && (sum_b[BW-1] != x[BW-1]);
    end
    if (shr) begin
      f      = {1'b0, pre[W-1:1]};
      c_word = pre[0];
      c_byte = pre[0];
      v_word = 1'b0;
      v_byte = 1'b0;
    end else begin
      f      = pre;
      c_word = cw;
      c_byte = cb;
      v_word = vw;
      v_byte = vb;
    end
  end
endmodule

// File: rtl/dp_flags.sv
module dp_flags import dp_pkg::*; (
  input  logic [W-1:0]    f,
  input  logic            c_word,
  input  logic            c_byte,
  input  logic            v_word,
  input  logic            v_byte,
  input  fl_e             sel,
  output logic [NFLG-1:0] flags_nx,
  output logic            flags_we
);
  always_comb begin
    flags_we = (sel != FL_NONE);
    case (sel)
      FL_HI:   flags_nx = {v_word, f[W-1], f[W-1:BW] == '0, c_word};
      FL_LO:   flags_nx = {v_byte, f[BW-1], f[BW-1:0] == '0, c_byte};
      default: flags_nx = {v_word, f[W-1], f == '0, c_word};
    endcase
  end
endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath import dp_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [UW-1:0] uword,
  input  logic [BW-1:0] mem_rdata,
  output logic [W-1:0]  mem_addr,
  output logic [BW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          seg_data,
  output logic          priv,
  output logic          ir_load,
  output logic [W-1:0]  alu_out
);
  ctl_t            c;
  logic [NLD-1:0]  ld_oh;
  logic [W-1:0]    r_mdr, r_a, r_x, r_y, r_mar, r_sp, r_dp, r_pc, r_msw;
  logic [W-1:0]    lbus, rbus, wbus;
  logic            c_word, c_byte, v_word, v_byte;
  logic [NFLG-1:0] flags_nx;
  logic            flags_we;

  dp_decode u_dec (.uword(uword), .ctl(c), .ld_oh(ld_oh));

  always_comb begin
    case (c.lsel)
      2'd0:    lbus = r_mdr;
      2'd1:    lbus = r_a;
      2'd2:    lbus = r_x;
      default: lbus = r_y;
    endcase
    case (c.asel)
      2'd0:    mem_addr = r_mar;
      2'd1:    mem_addr = r_sp;
      2'd2:    mem_addr = r_dp;
      default: mem_addr = r_pc;
    endcase
    case (c.rsel)
      2'd0:    rbus = r_mdr;
      2'd1:    rbus = r_msw;
      2'd2:    rbus = mem_addr;
      default: rbus = '0;
    endcase
  end

  dp_alu u_alu (
    .a(lbus), .b(rbus), .fn(c.fn), .lmode(c.lmode), .cin(c.cin), .shr(c.shr),
    .f(alu_out), .c_word(c_word), .c_byte(c_byte), .v_word(v_word), .v_byte(v_byte)
  );

  dp_flags u_flg (
    .f(alu_out), .c_word(c_word), .c_byte(c_byte), .v_word(v_word), .v_byte(v_byte),
    .sel(c.fl), .flags_nx(flags_nx), .flags_we(flags_we)
  );

  // Bus interface: a read mode replaces one byte of the write value.
  always_comb begin
    mem_re    = c.ben && !c.bmode[1];
    mem_we    = c.ben && c.bmode[1] && ld_oh[LD_MEM];
    mem_wdata = (c.bmode == BI_WRLO) ? alu_out[BW-1:0] : alu_out[W-1:BW];
    wbus      = alu_out;
    if (mem_re) begin
      if (c.bmode == BI_RDLO) wbus[BW-1:0] = mem_rdata;
      else                    wbus[W-1:BW] = mem_rdata;
    end
  end

  assign seg_data = c.seg;
  assign priv     = c.priv;
  assign ir_load  = c.ir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_mdr <= '0; r_a <= '0; r_x <= '0; r_y <= '0; r_mar <= '0;
      r_sp <= '0; r_dp <= '0; r_pc <= '0; r_msw <= '0;
    end else begin
      r_mdr <= merge_bytes(r_mdr, ld_oh[LD_MDRL] | ld_oh[LD_MDR],
                           ld_oh[LD_MDRH] | ld_oh[LD_MDR], wbus);
      r_a   <= merge_bytes(r_a, ld_oh[LD_AL] | ld_oh[LD_A],
                           ld_oh[LD_AH] | ld_oh[LD_A], wbus);
      if (ld_oh[LD_X])  r_x  <= wbus;
      if (ld_oh[LD_Y])  r_y  <= wbus;
      if (ld_oh[LD_DP]) r_dp <= wbus;

      if (ld_oh[LD_MARL] | ld_oh[LD_MARH] | ld_oh[LD_MAR])
        r_mar <= merge_bytes(r_mar, ld_oh[LD_MARL] | ld_oh[LD_MAR],
                             ld_oh[LD_MARH] | ld_oh[LD_MAR], wbus);
      else if (c.inc_mar)
        r_mar <= r_mar + 1'b1;

      if (ld_oh[LD_PC])    r_pc <= wbus;
      else if (c.inc_pc)   r_pc <= r_pc + 1'b1;

      if (ld_oh[LD_SP])                  r_sp <= wbus;
      else if (c.inc_sp && !c.dec_sp)    r_sp <= r_sp + 1'b1;
      else if (c.dec_sp && !c.inc_sp)    r_sp <= r_sp - 1'b1;

      if (ld_oh[LD_MSW])   r_msw <= wbus;
      else if (flags_we)   r_msw[NFLG-1:0] <= flags_nx;
    end
  end
endmodule

// File: rtl/dp_checker.sv
module dp_checker import dp_pkg::*; (
  input logic         clk,
  input logic         rst_n,
  input ctl_t         ctl,
  input logic         mem_we,
  input logic         mem_re,
  input logic [W-1:0] sp_q,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] msw_q
);
  // R6: a write needs the enable, a write mode and the memory destination
  p_we_mem_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ctl.ben && ctl.bmode[1] && ctl.ld == LD_MEM));

  // R6: read and write never coincide
  p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R9: opposite SP steps cancel
  p_sp_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.inc_sp && ctl.dec_sp && ctl.ld != LD_SP) |=> (sp_q == $past(sp_q)));

  // R9: lone SP increment
  p_sp_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.inc_sp && !ctl.dec_sp && ctl.ld != LD_SP) |=> (sp_q == $past(sp_q) + 16'd1));

  // R9: PC increment when not loaded
  p_pc_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.inc_pc && ctl.ld != LD_PC) |=> (pc_q == $past(pc_q) + 16'd1));

  // R8: flags hold when neither latched nor loaded
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fl == FL_NONE && ctl.ld != LD_MSW) |=> (msw_q == $past(msw_q)));
endmodule

bind ucode_datapath dp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(c), .mem_we(mem_we), .mem_re(mem_re),
  .sp_q(r_sp), .pc_q(r_pc), .msw_q(r_msw)
);

// File: tb/sim_ucode_datapath.sv
`timescale 1ns/1ps
module sim_ucode_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] uword = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re, seg_data, priv, ir_load;
  logic [15:0] alu_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mem [256];
  logic [15:0] m_mdr, m_a, m_x, m_y, m_mar, m_sp, m_dp, m_pc, m_msw;
  logic [15:0] seen_f, seen_a;

  always #10 clk = ~clk;

  ucode_datapath u0 (
    .clk(clk), .rst_n(rst_n), .uword(uword), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .seg_data(seg_data), .priv(priv), .ir_load(ir_load), .alu_out(alu_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int ls, input int rs, input int asl,
      input int bm, input int be, input int ld, input int fn, input int lg,
      input int ci, input int sh, input int fl, input int ipc, input int imar,
      input int isp, input int dsp, input int seg, input int pv, input int ir);
    logic [31:0] u;
    u = '0;
    u[1:0] = ls[1:0];   u[3:2] = rs[1:0];   u[5:4] = asl[1:0];
    u[7:6] = bm[1:0];   u[8] = be[0];       u[12:9] = ld[3:0];
    u[13] = ir[0];      u[17:14] = fn[3:0]; u[18] = lg[0];
    u[19] = ci[0];      u[20] = sh[0];      u[22:21] = fl[1:0];
    u[23] = ipc[0];     u[24] = imar[0];    u[25] = isp[0];
    u[26] = dsp[0];     u[27] = seg[0];     u[28] = pv[0];
    return u;
  endfunction

  // Left operand passed through, load code 8 with interface off: no state change.
  function automatic logic [31:0] peek_l(input int sel, input int asl);
    return mk(sel, 0, asl, 0, 0, 8, 15, 1, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0);
  endfunction
  function automatic logic [31:0] peek_r(input int sel, input int asl);
    return mk(0, sel, asl, 0, 0, 8, 10, 1, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0);
  endfunction

  // Bench ALU model: returns {c16, c8, v16, v8, f}.
  function automatic logic [19:0] m_alu(input int fn, input bit lg, input bit ci,
      input bit sh, input logic [15:0] a, input logic [15:0] b);
    int x, y, s, sb, sx, sy, bx, by;
    logic [15:0] f;
    logic c16, c8, v16, v8;
    c16 = 0; c8 = 0; v16 = 0; v8 = 0;
    if (lg) begin
      case (fn)
        0: f = ~a;         1: f = ~a & ~b;     2: f = b & ~a;   3: f = 16'h0000;
        4: f = ~a | ~b;    5: f = ~b;          6: f = (a & ~b) | (~a & b);
        7: f = a & ~b;     8: f = b | ~a;      9: f = (a & b) | (~a & ~b);
        10: f = b;         11: f = b & a;      12: f = 16'hFFFF;
        13: f = ~b | a;    14: f = b | a;      default: f = a;
      endcase
    end else begin
      case (fn)
        0: begin x = a; y = 0; end
        1: begin x = a | b; y = 0; end
        2: begin x = 32'(a | ~b); y = 0; end
        3: begin x = 0; y = 65535; end
        4: begin x = a; y = 32'(a & ~b); end
        5: begin x = a | b; y = 32'(a & ~b); end
        6: begin x = a; y = 32'(~b); end
        7: begin x = 32'(a & ~b); y = 65535; end
        8: begin x = a; y = a & b; end
        9: begin x = a; y = b; end
        10: begin x = 32'(a | ~b); y = a & b; end
        11: begin x = a & b; y = 65535; end
        12: begin x = a; y = a; end
        13: begin x = a | b; y = a; end
        14: begin x = 32'(a | ~b); y = a; end
        default: begin x = a; y = 65535; end
      endcase
      x = x & 65535; y = y & 65535;
      s = x + y + int'(ci);
      f = s[15:0];
      c16 = (s > 65535);
      sb = (x & 255) + (y & 255) + int'(ci);
      c8 = (sb > 255);
      sx = (x >= 32768) ? x - 65536 : x;
      sy = (y >= 32768) ? y - 65536 : y;
      v16 = (sx + sy + int'(ci) > 32767) || (sx + sy + int'(ci) < -32768);
      bx = ((x & 255) >= 128) ? (x & 255) - 256 : (x & 255);
      by = ((y & 255) >= 128) ? (y & 255) - 256 : (y & 255);
      v8 = (bx + by + int'(ci) > 127) || (bx + by + int'(ci) < -128);
    end
    if (sh) begin
      c16 = f[0]; c8 = f[0]; v16 = 0; v8 = 0;
      f = f >> 1;
    end
    return {c16, c8, v16, v8, f};
  endfunction

  task automatic step(input logic [31:0] uw);
    int ls, rs, asl, bm, ld, fn, fl;
    bit be, lg, ci, sh;
    logic [15:0] lb, rb, ab, f, wv;
    logic [19:0] r;
    logic [7:0] rd;
    bit ere, ewe;
    @(negedge clk);
    uword = uw;
    #2;
    ls = int'(uw[1:0]); rs = int'(uw[3:2]); asl = int'(uw[5:4]); bm = int'(uw[7:6]);
    be = uw[8]; ld = int'(uw[12:9]); fn = int'(uw[17:14]); lg = uw[18];
    ci = uw[19]; sh = uw[20]; fl = int'(uw[22:21]);
    lb = (ls == 0) ? m_mdr : (ls == 1) ? m_a : (ls == 2) ? m_x : m_y;
    ab = (asl == 0) ? m_mar : (asl == 1) ? m_sp : (asl == 2) ? m_dp : m_pc;
    rb = (rs == 0) ? m_mdr : (rs == 1) ? m_msw : (rs == 2) ? ab : 16'h0;
    r = m_alu(fn, lg, ci, sh, lb, rb);
    f = r[15:0];
    chk("R4 mem_addr", 32'(mem_addr), 32'(ab));
    chk("R3/R7 alu_out", 32'(alu_out), 32'(f));
    ere = be && (bm < 2);
    ewe = be && (bm >= 2) && (ld == 8);
    chk("R6 mem_re", 32'(mem_re), 32'(ere));
    chk("R6 mem_we", 32'(mem_we), 32'(ewe));
    if (ewe) chk("R6 mem_wdata", 32'(mem_wdata), 32'((bm == 2) ? f[7:0] : f[15:8]));
    chk("R10 seg/priv/ir", {29'd0, seg_data, priv, ir_load}, {29'd0, uw[27], uw[28], uw[13]});
    seen_f = alu_out; seen_a = mem_addr;
    rd = mem[ab[7:0]];
    wv = f;
    if (ere) begin
      if (bm == 0) wv[7:0] = rd; else wv[15:8] = rd;
    end
    case (ld)
      0: m_mdr[7:0] = wv[7:0];    1: m_mdr[15:8] = wv[15:8];  2: m_mdr = wv;
      3: m_a[7:0] = wv[7:0];      4: m_a[15:8] = wv[15:8];    5: m_a = wv;
      6: m_x = wv;                7: m_y = wv;
      9: m_mar[7:0] = wv[7:0];    10: m_mar[15:8] = wv[15:8]; 11: m_mar = wv;
      12: m_sp = wv;              13: m_dp = wv;              14: m_pc = wv;
      15: m_msw = wv;
      default: ;
    endcase
    if (uw[23] && ld != 14) m_pc = m_pc + 1;
    if (uw[24] && !(ld == 9 || ld == 10 || ld == 11)) m_mar = m_mar + 1;
    if (ld != 12 && uw[25] && !uw[26]) m_sp = m_sp + 1;
    if (ld != 12 && uw[26] && !uw[25]) m_sp = m_sp - 1;
    if (ld != 15 && fl != 3) begin
      case (fl)
        0: m_msw[3:0] = {r[17], f[15], f == 16'h0, r[19]};
        1: m_msw[3:0] = {r[17], f[15], f[15:8] == 8'h0, r[19]};
        default: m_msw[3:0] = {r[16], f[7], f[7:0] == 8'h0, r[18]};
      endcase
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] u;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[1] = 8'h10; mem[8'h11] = 8'hFF;
    m_mdr = 0; m_a = 0; m_x = 0; m_y = 0; m_mar = 0;
    m_sp = 0; m_dp = 0; m_pc = 0; m_msw = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: reset state
    for (int s = 0; s < 4; s++) begin
      step(peek_l(s, s));
      chk("R2 reset left source", 32'(seen_f), 0);
      chk("R2 reset address source", 32'(seen_a), 0);
    end
    step(peek_r(1, 0));
    chk("R2 reset MSW", 32'(seen_f), 0);

    // R5/R6: MDR assembled byte by byte from code at PC
    step(mk(0,0,3, 1,1,1, 0,0,0,0,3, 1,0,0,0, 0,0,0));
    step(mk(0,0,3, 0,1,0, 0,0,0,0,3, 1,0,0,0, 0,0,0));
    step(mk(0,0,0, 0,0,11, 15,1,0,0,3, 0,0,0,0, 0,0,0));
    step(peek_l(0, 0));
    chk("R5 MAR loaded from MDR", 32'(seen_a), 32'h0010);
    step(mk(0,0,0, 1,1,4, 0,0,0,0,3, 0,1,0,0, 1,0,0));
    step(mk(0,0,0, 0,1,3, 0,0,0,0,3, 0,0,0,0, 1,0,0));
    step(peek_l(1, 3));
    chk("R5/R6 A from two byte reads", 32'(seen_f), 32'h00FF);
    chk("R9 PC after two steps", 32'(seen_a), 32'h0002);

    // R8: flag widths. A=0x00FF plus carry-in into A, low byte latch
    step(mk(1,0,0, 0,0,5, 0,0,1,0,2, 0,0,0,0, 0,0,0));
    step(peek_r(1, 0));
    chk("R8 low-byte flags C=1 Z=1", 32'(seen_f), 32'h0003);
    step(mk(1,0,0, 0,0,8, 3,1,0,0,3, 0,0,0,0, 0,0,0));
    step(peek_r(1, 0));
    chk("R8 no-update mode keeps flags", 32'(seen_f), 32'h0003);
    step(mk(1,0,0, 0,0,8, 0,0,0,0,0, 0,0,0,0, 0,0,0));
    step(peek_r(1, 0));
    chk("R8 word flags all clear for 0x0100", 32'(seen_f), 32'h0000);
    step(mk(1,0,0, 0,0,8, 15,0,0,0,1, 0,0,0,0, 0,0,0));
    chk("R7 A minus one", 32'(seen_f), 32'h00FF);
    step(peek_r(1, 0));
    chk("R8 high-byte flags C=1 Z=1", 32'(seen_f), 32'h0003);

    // R9: stack pointer steps
    step(mk(0,0,1, 0,0,8, 0,0,0,0,3, 0,0,1,0, 0,0,0));
    step(mk(0,0,1, 0,0,8, 0,0,0,0,3, 0,0,1,1, 0,0,0));
    chk("R9 SP after increment", 32'(seen_a), 32'h0001);
    step(mk(0,0,1, 0,0,8, 0,0,0,0,3, 0,0,0,1, 0,0,0));
    chk("R9 SP unchanged by inc+dec", 32'(seen_a), 32'h0001);
    step(mk(0,0,1, 0,0,8, 0,0,0,0,3, 0,0,0,1, 0,0,0));
    step(peek_l(0, 1));
    chk("R9 SP wraps below zero", 32'(seen_a), 32'hFFFF);
    step(mk(0,0,3, 0,0,14, 15,1,0,0,3, 1,0,0,0, 0,0,0));
    step(peek_l(0, 3));
    chk("R9 load wins over PC increment", 32'(seen_a), 32'h0010);

    // R3: right-bus address and zero codes
    step(peek_r(2, 3));
    chk("R3 right bus carries address", 32'(seen_f), 32'h0010);
    step(peek_r(3, 3));
    chk("R3 right bus code 3 is zero", 32'(seen_f), 32'h0000);

    // R7: A=0x0100, MDR=0x0010
    step(mk(1,0,0, 0,0,8, 6,0,1,0,3, 0,0,0,0, 0,0,0));
    chk("R7 A minus B with carry", 32'(seen_f), 32'h00F0);
    step(mk(1,0,0, 0,0,8, 6,1,0,0,3, 0,0,0,0, 0,0,0));
    chk("R7 xor", 32'(seen_f), 32'h0110);
    step(mk(1,0,0, 0,0,8, 15,1,0,1,3, 0,0,0,0, 0,0,0));
    chk("R7 right shift", 32'(seen_f), 32'h0080);

    // R6: stores to MAR=0x0011
    step(mk(1,0,0, 2,1,8, 15,1,0,0,3, 0,0,0,0, 0,0,0));
    chk("R6 low byte stored", 32'(mem[8'h11]), 32'h00);
    step(mk(1,0,0, 3,1,8, 15,1,0,0,3, 0,0,0,0, 0,0,0));
    chk("R6 high byte stored", 32'(mem[8'h11]), 32'h01);
    step(mk(2,0,0, 3,0,8, 15,1,0,0,3, 0,0,0,0, 0,0,0));
    chk("R6 disabled interface does not write", 32'(mem[8'h11]), 32'h01);
    step(mk(2,0,0, 3,1,6, 15,1,0,0,3, 0,0,0,0, 0,0,0));
    chk("R6 non-memory destination does not write", 32'(mem[8'h11]), 32'h01);

    // R10 and R1 spare bits
    step(mk(0,0,0, 0,0,8, 0,0,0,0,3, 0,0,0,0, 1,1,1) | 32'hE000_0000);
    step(peek_l(1, 0));
    chk("R1 spare bits ignored", 32'(seen_f), 32'h0100);

    // Random control words against the model (R1..R10)
    for (int i = 0; i < 4000; i++) begin
      u = $urandom();
      step(u);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule